// File: doc/BRIEF.md
# Command-Driven Counter/Timer Unit

This block is a 16-bit down counter with a byte-wide register interface. Software writes a preset one byte at a time and selects one of three operating modes. Reads at two fixed addresses also act as commands. A read at 0xE starts the counter from the preset. A read at 0xF stops it, captures the current count into two readable bytes and clears the ready flag. An external single-cycle enable tick paces the counting. The tick stands in for a prescaler or a clock-source selector.

The unit drives one output line, whose waveform depends on the mode. In timer mode the line is a square wave with a half-period of the preset. In counter mode the line falls at terminal count and stays low until a stop command. The time-out mode is armed by writing the mode register. In this mode the start and stop commands have no effect, and a terminal count pulls the line low for good. The ready flag goes to an interrupt status register outside this block.

Top module: `ctu_top`

## Requirements
- R1: After reset the output is high, ready is low, the mode is timer, and reads of the value bytes return 0.
- R2: A write at address 0x0 sets preset bits 7:0. A write at 0x1 sets bits 15:8. A write at 0x2 sets the mode from data bits 1:0: 00 is timer, 01 is counter, and 1x is time-out.
- R3: Outside time-out mode, a read at 0xE loads the count from the preset, sets the output high and starts counting. Each cycle with the tick high then lowers the count by one.
- R4: A preset of 0 counts as 65536 ticks.
- R5: In timer mode the output toggles on the tick that brings the count to zero, and the count reloads from the preset. One full output period is therefore twice the preset in ticks.
- R6: In counter mode the output falls on the terminal-count tick and counting halts. The output stays low until a stop command.
- R7: Ready rises on every terminal-count tick and stays set until a stop command or reset clears it.
- R8: Outside time-out mode, a read at 0xF halts counting, sets the output high and clears ready. It also captures count bits 15:0, which then read back at 0x4 (bits 7:0) and 0x5 (bits 15:8).
- R9: Writing a time-out mode value loads the preset and starts counting. On terminal count the output goes low, ready sets and counting halts. Reads at 0xE and 0xF have no effect in this mode.
- R10: A start or stop command in the same cycle as a tick takes priority over the tick. A stop captures the count as it was before that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; triggers commands at 0xE/0xF |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high |
| tick | input | 1 | Count enable, one decrement per high cycle |
| ct_out | output | 1 | Mode-dependent output line |
| ct_ready | output | 1 | Terminal-count flag for the interrupt status register |

## Verification
The assertions check, on every cycle, the following:
- a stop clears ready, halts counting, raises the line and captures the previous count;
- a plain tick lowers the count by exactly one;
- a terminal-count tick sets ready;
- a low output with the counter idle stays low without a command;
- the count never exceeds 65536.

Only the bench scenarios can show the following:
- the square-wave period across a sweep of presets;
- the 65536-tick cycle of a zero preset;
- the byte placement of captured values;
- the commands being ignored in time-out mode.

// File: rtl/ctu_pkg.sv
// Package: shared mode encoding and register addresses for the counter/timer unit.
// Assumes a 4-bit byte address space.
package ctu_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        MODE_TIMER   = 2'b00,
        MODE_COUNTER = 2'b01,
        MODE_TOUT    = 2'b10,
        MODE_TOUT_B  = 2'b11
    } ctu_mode_e;

    localparam logic [ADDR_W-1:0] A_PRESET_LO = 4'h0;
    localparam logic [ADDR_W-1:0] A_PRESET_HI = 4'h1;
    localparam logic [ADDR_W-1:0] A_MODE      = 4'h2;
    localparam logic [ADDR_W-1:0] A_VALUE_LO  = 4'h4;
    localparam logic [ADDR_W-1:0] A_VALUE_HI  = 4'h5;
    localparam logic [ADDR_W-1:0] A_CMD_START = 4'hE;
    localparam logic [ADDR_W-1:0] A_CMD_STOP  = 4'hF;
endpackage

// File: rtl/ctu_regs.sv
// Module: ctu_regs
// Holds the preset and the mode register, and muxes the captured value bytes onto the read bus.
// Assumes the counter width is exactly two data bytes; read data is combinational during bus_rd.
module ctu_regs
    import ctu_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  value_q,
    output logic [CNT_W-1:0]  preset_q,
    output ctu_mode_e         mode_q,
    output logic              arm_p,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int HI_LSB = CNT_W - DATA_W;

    // Capture preset bytes and mode on bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preset_q <= '0;
            mode_q   <= MODE_TIMER;
        end else if (bus_wr) begin
            case (bus_addr)
                A_PRESET_LO: preset_q[DATA_W-1:0]     <= bus_wdata;
                A_PRESET_HI: preset_q[CNT_W-1:HI_LSB] <= bus_wdata;
                A_MODE:      mode_q <= ctu_mode_e'(bus_wdata[1:0]);
                default: ;
            endcase
        end
    end

    // Arming pulse when a time-out mode value is written.
    always_comb arm_p = bus_wr && (bus_addr == A_MODE) && bus_wdata[1];

    // Read mux for the captured value bytes.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == A_VALUE_LO) bus_rdata = value_q[DATA_W-1:0];
            else if (bus_addr == A_VALUE_HI) bus_rdata = value_q[CNT_W-1:HI_LSB];
        end
    end
endmodule

// File: rtl/ctu_cmd.sv
// Module: ctu_cmd
// Turns reads at the command addresses into single-cycle start/stop strobes.
// Assumes one read per cycle at most; time-out mode suppresses both strobes.
module ctu_cmd
    import ctu_pkg::*;
(
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  ctu_mode_e         mode_q,
    output logic              start_p,
    output logic              stop_p
);
    logic tout_mode;

    // Time-out mode is any mode value with bit 1 set.
    always_comb tout_mode = mode_q[1];

    // Decode the command reads, gated by the mode.
    always_comb begin
        start_p = bus_rd && (bus_addr == A_CMD_START) && !tout_mode;
        stop_p  = bus_rd && (bus_addr == A_CMD_STOP)  && !tout_mode;
    end
endmodule

// File: rtl/ctu_core.sv
// Module: ctu_core
// Down counter with a mode-dependent output line, a ready flag and a stop-time capture register.
// Assumes single-cycle strobes; commands outrank the tick; a zero preset means 2**CNT_W ticks.
module ctu_core
    import ctu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start_p,
    input  logic             stop_p,
    input  logic             arm_p,
    input  ctu_mode_e        mode_q,
    input  logic [CNT_W-1:0] preset_q,
    output logic [CNT_W-1:0] value_q,
    output logic             out_q,
    output logic             ready_q
);
    localparam int          CW   = CNT_W + 1;
    localparam logic [CW-1:0] FULL = CW'(1) << CNT_W;

    logic [CW-1:0] count_q;
    logic [CW-1:0] load_val;
    logic          running_q;
    logic          terminal;
    logic          any_cmd;

    // Effective reload value: zero preset stands for a full 2**CNT_W span.
    always_comb load_val = (preset_q == '0) ? FULL : {1'b0, preset_q};

    // Terminal tick and command presence.
    always_comb begin
        terminal = running_q && tick && (count_q == CW'(1));
        any_cmd  = start_p || stop_p || arm_p;
    end

    // Counter, output line, ready flag and capture register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            running_q <= 1'b0;
            out_q     <= 1'b1;
            ready_q   <= 1'b0;
            value_q   <= '0;
        end else if (start_p || arm_p) begin
            count_q   <= load_val;
            running_q <= 1'b1;
            out_q     <= 1'b1;
        end else if (stop_p) begin
            running_q <= 1'b0;
            value_q   <= count_q[CNT_W-1:0];
            ready_q   <= 1'b0;
            out_q     <= 1'b1;
        end else if (terminal) begin
            ready_q <= 1'b1;
            if (mode_q == MODE_TIMER) begin
                count_q <= load_val;
                out_q   <= ~out_q;
            end else begin
                count_q   <= '0;
                running_q <= 1'b0;
                out_q     <= 1'b0;
            end
        end else if (running_q && tick) begin
            count_q <= count_q - CW'(1);
        end
    end

    // R8
    stop_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p && !start_p && !arm_p |=> !ready_q && out_q && !running_q
                                         && value_q == $past(count_q[CNT_W-1:0]));
    // R3
    tick_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running_q && tick && !any_cmd && count_q > CW'(1) |=> count_q == $past(count_q) - CW'(1));
    // R7
    ready_on_terminal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        terminal && !any_cmd |=> ready_q);
    // R6
    low_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_q && !running_q && !any_cmd |=> !out_q);
    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL);
endmodule

// File: rtl/ctu_top.sv
// Module: ctu_top
// Command-driven counter/timer: register file, command decoder and counting core.
// Assumes CNT_W == 2*DATA_W so the value splits into two readable bytes.
module ctu_top
    import ctu_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick,
    output logic              ct_out,
    output logic              ct_ready
);
    logic [CNT_W-1:0] preset_q;
    logic [CNT_W-1:0] value_q;
    ctu_mode_e        mode_q;
    logic             arm_p;
    logic             start_p;
    logic             stop_p;

    ctu_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .value_q(value_q),
        .preset_q(preset_q), .mode_q(mode_q), .arm_p(arm_p), .bus_rdata(bus_rdata)
    );

    ctu_cmd u_cmd (
        .bus_rd(bus_rd), .bus_addr(bus_addr), .mode_q(mode_q),
        .start_p(start_p), .stop_p(stop_p)
    );

    ctu_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start_p(start_p), .stop_p(stop_p),
        .arm_p(arm_p), .mode_q(mode_q), .preset_q(preset_q), .value_q(value_q),
        .out_q(ct_out), .ready_q(ct_ready)
    );
endmodule

// File: tb/ctu_top_bench.sv
`timescale 1ns/1ps
module ctu_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tick = 1'b0;
    logic       ct_out;
    logic       ct_ready;
    int         total = 0;
    int         bad = 0;
    logic       done = 1'b0;

    always #4 clk = ~clk;

    ctu_top u_ctu_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
        .ct_out(ct_out), .ct_ready(ct_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Each task starts at a falling edge and returns at the next falling edge it needs.
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic tk, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1; tick = tk;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic set_preset(input logic [15:0] p);
        wr(4'h0, p[7:0]);
        wr(4'h1, p[15:8]);
    endtask

    task automatic read_value(input string req, input logic [15:0] exp);
        logic [7:0] lo;
        logic [7:0] hi;
        rd(4'h4, 1'b0, lo);
        rd(4'h5, 1'b0, hi);
        chk(req, {16'h0, hi, lo}, {16'h0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int tn [6] = '{1, 2, 3, 5, 7, 200};
        int cn [4] = '{1, 3, 4, 9};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 out", ct_out, 1);
        chk("R1 ready", ct_ready, 0);
        read_value("R1 value", 16'h0);

        // R2 R3 R5 R7 R8: timer sweep
        foreach (tn[i]) begin
            int n = tn[i];
            wr(4'h2, 8'h00);
            set_preset(16'(n));
            rd(4'hE, 1'b0, d);
            ticks(n - 1);
            chk("R5 out before terminal", ct_out, 1);
            chk("R7 ready before terminal", ct_ready, 0);
            ticks(1);
            chk("R5 out toggles", ct_out, 0);
            chk("R7 ready set", ct_ready, 1);
            ticks(n);
            chk("R5 second toggle", ct_out, 1);
            chk("R7 ready held", ct_ready, 1);
            rd(4'hF, 1'b0, d);
            chk("R8 ready cleared", ct_ready, 0);
            read_value("R5 reload captured", 16'(n));
        end

        // R6 counter sweep
        foreach (cn[i]) begin
            int n = cn[i];
            wr(4'h2, 8'h01);
            set_preset(16'(n));
            rd(4'hE, 1'b0, d);
            ticks(n);
            chk("R6 out low at terminal", ct_out, 0);
            chk("R7 ready counter", ct_ready, 1);
            ticks(3);
            chk("R6 out stays low", ct_out, 0);
            rd(4'hF, 1'b0, d);
            chk("R6 out high after stop", ct_out, 1);
            read_value("R6 halted at zero", 16'h0);
        end

        // R8 partial capture with both bytes
        wr(4'h2, 8'h00);
        set_preset(16'h1234);
        rd(4'hE, 1'b0, d);
        ticks(16'h34);
        rd(4'hF, 1'b0, d);
        read_value("R8 capture", 16'h1200);
        ticks(10);
        read_value("R8 halted", 16'h1200);

        // R10 command priority over tick
        set_preset(16'd10);
        rd(4'hE, 1'b0, d);
        ticks(4);
        rd(4'hF, 1'b1, d);
        read_value("R10 stop before tick", 16'd6);
        rd(4'hE, 1'b1, d);
        ticks(9);
        chk("R10 start ignores tick", ct_out, 1);
        ticks(1);
        chk("R10 terminal after full span", ct_out, 0);
        rd(4'hF, 1'b0, d);

        // R4 zero preset
        set_preset(16'h0000);
        rd(4'hE, 1'b0, d);
        ticks(65535);
        chk("R4 no toggle at 65535", ct_out, 1);
        ticks(1);
        chk("R4 toggle at 65536", ct_out, 0);
        rd(4'hF, 1'b0, d);

        // R9 time-out mode
        set_preset(16'd5);
        read_value("R9 prior capture", 16'h0);
        wr(4'h2, 8'h02);
        ticks(2);
        rd(4'hF, 1'b0, d);
        read_value("R9 stop ignored", 16'h0);
        chk("R9 out still high", ct_out, 1);
        rd(4'hE, 1'b0, d);
        ticks(2);
        chk("R9 start did not reload", ct_out, 1);
        ticks(1);
        chk("R9 out low at terminal", ct_out, 0);
        chk("R9 ready", ct_ready, 1);
        rd(4'hF, 1'b0, d);
        chk("R9 ready kept", ct_ready, 1);
        chk("R9 out kept low", ct_out, 0);
        rd(4'hE, 1'b0, d);
        ticks(8);
        chk("R9 start ignored", ct_out, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule